// File: doc/BRIEF.md
# Power-Up Reset Delay Sequencer

This block keeps the rest of the chip in reset after power is applied until the supply can be trusted and, when a crystal or resonator drives the device clock, until that oscillator has swung steadily for a fixed number of cycles. It runs three stages one after another. The first is a supply-settling timer that counts pulses of a slow timebase. The second counts cycles of the oscillator itself. The third is a short settling interval counted in system clock cycles. Only when the third stage ends does the internal reset drop.

The power-on pulse acts as an asynchronous reset for the whole block. Raising it at any stage throws the sequence back to the supply timer. The oscillator-cycle counter lives in the oscillator's own clock domain. Its start request goes into that domain through a two-flop synchronizer, and its done flag comes back through another two-flop synchronizer. Each completed stage raises a flag that stays high until the next power-on pulse.

Top module: `pwrup_seq`

## Requirements
- R1: While `por_i` is high, `rst_o` is 1 and both `pwrt_done_o` and `ost_done_o` are 0, at any point in the sequence.
- R2: With `pwrt_en_i` high, `pwrt_done_o` rises at the clock edge that samples the `PWRT_TICKS`-th high `tick_i` after `por_i` falls. Clock cycles with `tick_i` low do not advance the count.
- R3: With `pwrt_en_i` low, `pwrt_done_o` rises at the first clock edge after `por_i` falls, and no tick is needed.
- R4: The block reads `osc_mode_i` when the supply stage ends. Codes 0 (low-power crystal), 1 (standard crystal) and 2 (high-speed crystal) insert the oscillator stage. In that stage `ost_done_o` rises only after `OST_CYCLES` rising edges of `osc_clk_i` plus the synchronizer delays. While `osc_clk_i` is stopped, `ost_done_o` stays 0 and `rst_o` stays 1.
- R5: Codes 3 to 7 of `osc_mode_i` (clocks that are not crystals) skip the oscillator stage, so `ost_done_o` rises at the same edge as `pwrt_done_o`.
- R6: `rst_o` falls exactly `SETTLE_CYC` clock edges after the edge at which `ost_done_o` rises.
- R7: A `por_i` pulse at any stage clears both flags, and after it the supply timer again needs a full `PWRT_TICKS` ticks.
- R8: Once `rst_o` is 0, it stays 0 and both flags stay 1 until the next `por_i`. Ticks and changes on `osc_mode_i` or `pwrt_en_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| por_i | input | 1 | Power-on pulse, active high, asynchronous reset |
| tick_i | input | 1 | One-cycle timebase pulse, synchronous to clk_i |
| osc_clk_i | input | 1 | Oscillator clock being qualified |
| osc_mode_i | input | 3 | Oscillator mode code: 0 to 2 are crystals, 3 to 7 are other clocks |
| pwrt_en_i | input | 1 | Enables the supply-settling timer |
| rst_o | output | 1 | Internal reset, active high |
| pwrt_done_o | output | 1 | Supply-settling stage finished |
| ost_done_o | output | 1 | Oscillator stage finished or skipped |

## Verification
The bench builds the block with `PWRT_TICKS`=4, `OST_CYCLES`=16 and `SETTLE_CYC`=3 instead of the 64/1024/8 defaults. Because the counts are small, the exact edge on which each tick count ends and the exact settling edge can be checked one by one. A full oscillator count at a 20 ns oscillator period takes about forty system cycles, short enough to cover a stopped oscillator, a late start and a restart in the middle of the sequence.

// File: rtl/pwrup_seq.sv
module pwrup_seq #(
  parameter int unsigned PWRT_TICKS = 64,
  parameter int unsigned OST_CYCLES = 1024,
  parameter int unsigned SETTLE_CYC = 8
) (
  input  logic       clk_i,
  input  logic       por_i,
  input  logic       tick_i,
  input  logic       osc_clk_i,
  input  logic [2:0] osc_mode_i,
  input  logic       pwrt_en_i,
  output logic       rst_o,
  output logic       pwrt_done_o,
  output logic       ost_done_o
);

  localparam int unsigned CMAX = (PWRT_TICKS > SETTLE_CYC) ? PWRT_TICKS : SETTLE_CYC;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam int unsigned OW   = $clog2(OST_CYCLES + 1);
  localparam logic [CW-1:0] PWRT_LAST   = CW'(PWRT_TICKS - 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [OW-1:0] OST_LAST    = OW'(OST_CYCLES - 1);

  typedef enum logic [1:0] {ST_PWR, ST_OSC, ST_SETTLE, ST_RUN} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          crystal;
  logic          go_osc;
  logic [1:0]    go_q;
  logic [OW-1:0] osc_cnt;
  logic          osc_done;
  logic [1:0]    done_q;
  logic          osc_done_s;

  assign crystal    = (osc_mode_i <= 3'd2);
  assign go_osc     = (st == ST_OSC);
  assign osc_done_s = done_q[1];

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) begin
      st  <= ST_PWR;
      cnt <= '0;
    end else begin
      case (st)
        ST_PWR: begin
          if (!pwrt_en_i || (tick_i && cnt == PWRT_LAST)) begin
            st  <= crystal ? ST_OSC : ST_SETTLE;
            cnt <= '0;
          end else if (tick_i) begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_OSC: begin
          if (osc_done_s) begin
            st  <= ST_SETTLE;
            cnt <= '0;
          end
        end
        ST_SETTLE: begin
          if (cnt == SETTLE_LAST) st <= ST_RUN;
          else                    cnt <= cnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge osc_clk_i or posedge por_i) begin
    if (por_i) go_q <= '0;
    else       go_q <= {go_q[0], go_osc};
  end

  always_ff @(posedge osc_clk_i or posedge por_i) begin
    if (por_i) begin
      osc_cnt  <= '0;
      osc_done <= 1'b0;
    end else if (!go_q[1]) begin
      osc_cnt  <= '0;
      osc_done <= 1'b0;
    end else if (!osc_done) begin
      if (osc_cnt == OST_LAST) osc_done <= 1'b1;
      else                     osc_cnt  <= osc_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_i or posedge por_i) begin
    if (por_i) done_q <= '0;
    else       done_q <= {done_q[0], osc_done};
  end

  assign rst_o       = (st != ST_RUN);
  assign pwrt_done_o = (st != ST_PWR);
  assign ost_done_o  = (st == ST_SETTLE) || (st == ST_RUN);

endmodule

module pwrup_seq_chk (
  input logic       clk_i,
  input logic       por_i,
  input logic       tick_i,
  input logic [2:0] osc_mode_i,
  input logic       pwrt_en_i,
  input logic       rst_o,
  input logic       pwrt_done_o,
  input logic       ost_done_o,
  input logic       osc_done_s
);

  always @(posedge clk_i) begin
    if (por_i) begin
      p_reset_held_r1: assert (rst_o && !pwrt_done_o && !ost_done_o)
        else $error("R1 outputs not in reset state");
    end
  end

  p_pwrt_cause_r2: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(pwrt_done_o) |-> ($past(tick_i) || !$past(pwrt_en_i)));

  p_osc_cause_r4: assert property (@(posedge clk_i) disable iff (por_i)
    ($rose(ost_done_o) && !$rose(pwrt_done_o)) |-> $past(osc_done_s));

  p_skip_mode_r5: assert property (@(posedge clk_i) disable iff (por_i)
    ($rose(pwrt_done_o) && $rose(ost_done_o)) |-> ($past(osc_mode_i) > 3'd2));

  p_settle_gap_r6: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(rst_o) |-> $past(ost_done_o));

  p_release_sticky_r8: assert property (@(posedge clk_i) disable iff (por_i)
    !rst_o |=> (!rst_o && pwrt_done_o && ost_done_o));

endmodule

bind pwrup_seq pwrup_seq_chk u_pwrup_seq_chk (
  .clk_i      (clk_i),
  .por_i      (por_i),
  .tick_i     (tick_i),
  .osc_mode_i (osc_mode_i),
  .pwrt_en_i  (pwrt_en_i),
  .rst_o      (rst_o),
  .pwrt_done_o(pwrt_done_o),
  .ost_done_o (ost_done_o),
  .osc_done_s (osc_done_s)
);

// File: tb/test_pwrup_seq.sv
module test_pwrup_seq;
  localparam int unsigned PT = 4;
  localparam int unsigned OC = 16;
  localparam int unsigned SC = 3;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic tick = 1'b0;
  logic osc_free = 1'b0;
  logic osc_run = 1'b1;
  logic osc_clk;
  logic [2:0] mode = 3'd4;
  logic pen = 1'b1;
  logic rst, pdone, odone;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;
  always #10 osc_free = ~osc_free;
  assign osc_clk = osc_free & osc_run;

  pwrup_seq #(.PWRT_TICKS(PT), .OST_CYCLES(OC), .SETTLE_CYC(SC)) i_pwrup_seq (
    .clk_i(clk), .por_i(por), .tick_i(tick), .osc_clk_i(osc_clk),
    .osc_mode_i(mode), .pwrt_en_i(pen), .rst_o(rst),
    .pwrt_done_o(pdone), .ost_done_o(odone));

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_por();
    @(negedge clk) por = 1'b1;
    repeat (2) @(negedge clk);
    chk("R7", "rst during por", rst, 1);
    chk("R7", "flags during por", {pdone, odone}, 0);
    por = 1'b0;
  endtask

  task automatic give_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic settle_check(input string tag);
    repeat (SC - 1) @(negedge clk);
    chk("R6", {tag, " rst before settle end"}, rst, 1);
    @(negedge clk);
    chk("R6", {tag, " rst after settle end"}, rst, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "rst at reset", rst, 1);
    chk("R1", "flags at reset", {pdone, odone}, 0);
  endtask

  task automatic t_no_crystal();
    mode = 3'd4; pen = 1'b1;
    do_por();
    repeat (10) @(negedge clk);
    chk("R2", "no advance without ticks", pdone, 0);
    for (int i = 0; i < int'(PT) - 1; i++) give_tick();
    chk("R2", "pwrt done one tick early", pdone, 0);
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    chk("R2", "pwrt done after last tick", pdone, 1);
    chk("R5", "osc stage skipped", odone, 1);
    settle_check("skip");
  endtask

  task automatic t_crystal(input logic [2:0] m);
    int n;
    mode = m; pen = 1'b1;
    do_por();
    for (int i = 0; i < int'(PT); i++) give_tick();
    chk("R4", "pwrt done crystal", pdone, 1);
    chk("R4", "osc stage entered", odone, 0);
    repeat (20) @(negedge clk);
    chk("R4", "osc count not yet done", odone, 0);
    n = 20;
    while (!odone && n < 200) begin @(negedge clk); n++; end
    chk("R4", "osc done arrived", odone, 1);
    chk("R4", "osc stage long enough", int'(n >= 38), 1);
    settle_check("crystal");
  endtask

  task automatic t_no_osc();
    int n;
    mode = 3'd2; pen = 1'b1; osc_run = 1'b0;
    do_por();
    for (int i = 0; i < int'(PT); i++) give_tick();
    repeat (300) @(negedge clk);
    chk("R4", "stopped osc keeps osc stage", odone, 0);
    chk("R4", "stopped osc keeps reset", rst, 1);
    osc_run = 1'b1;
    n = 0;
    while (!odone && n < 300) begin @(negedge clk); n++; end
    chk("R4", "late osc completes", odone, 1);
    settle_check("late osc");
  endtask

  task automatic t_pwrt_off();
    mode = 3'd5; pen = 1'b0;
    @(negedge clk) por = 1'b1;
    @(negedge clk) por = 1'b0;
    @(negedge clk);
    chk("R3", "pwrt off done at first edge", pdone, 1);
    chk("R5", "skip with pwrt off", odone, 1);
    settle_check("pwrt off");
    pen = 1'b1;
  endtask

  task automatic t_restart();
    mode = 3'd6; pen = 1'b1;
    do_por();
    for (int i = 0; i < int'(PT); i++) give_tick();
    chk("R7", "in settle before restart", {pdone, rst}, 3);
    do_por();
    for (int i = 0; i < int'(PT) - 1; i++) give_tick();
    chk("R7", "count restarted", pdone, 0);
    give_tick();
    chk("R7", "restart completes", pdone, 1);
    settle_check("restart");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 10; i++) give_tick();
    mode = 3'd0; pen = 1'b0;
    repeat (50) @(negedge clk);
    chk("R8", "rst stays released", rst, 0);
    chk("R8", "flags stay set", {pdone, odone}, 3);
    pen = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_no_crystal();
    t_hold();
    t_crystal(3'd1);
    t_crystal(3'd0);
    t_no_osc();
    t_pwrt_off();
    t_restart();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule